// File: doc/BRIEF.md
# Two-Channel Debug Break Comparator

This block watches the processor's instruction-fetch and memory-access buses and the internal bus shared by the CPU and the DMA engine. It raises a break request when an observed bus cycle matches a condition programmed into one of its channels. Each channel holds an address value and mask, a data value and mask, and a control word. The control word picks which side of the chip to watch, which internal master to watch, the cycle type, the direction, the operand size, and when a fetch break is taken.

The bus inputs are monitor taps. They carry a valid strobe but no ready, and the block never stalls a bus: a cycle counts once for every clock edge in which its valid is high. Configuration arrives on a plain write-only register port. Results come out as registered outputs: a per-channel request pulse, a per-channel "break after execution" marker, a shared trigger pulse, and per-channel sticky match flags.

Top module: `dbg_break_unit`

## Requirements
- R1: An address bit whose mask bit is 1 is ignored in the compare. With the whole address mask set, every address matches.
- R2: A data bit whose data-mask bit is 1 is ignored in the compare. The data compare applies only to memory-side and internal-bus cycles. Fetch cycles never check data.
- R3: With control bit 1 at 0 (processor side), the cycle-type field (bits 4:3, 0 any, 1 fetch, 2 data, 3 none) chooses the bus. Fetch watches the fetch bus, data watches the memory bus, and "any" accepts a hit on either.
- R4: With control bit 1 at 1 (internal side), bit 2 chooses the internal CPU bus (0) or the DMA bus (1). The other internal master and both processor-side buses are then ignored. Cycle type "fetch" never matches on this side.
- R5: The direction field (bits 6:5) is 0 any, 1 read only, 2 write only, 3 none. A bus `wr` of 1 marks a write.
- R6: The size field (bits 8:7) is 0 any, 1 byte, 2 word, 3 longword. It is compared with the bus size code, which uses the same values. Fetch cycles ignore both direction and size.
- R7: A channel whose enable (control bit 0) is 0 never requests a break. All registers reset to 0.
- R8: On a fetch match, `brk_after` goes high with the request when control bit 9 is 1, and stays low when bit 9 is 0 (break before execution). A data match never raises `brk_after`.
- R9: A request appears one clock after the bus cycle is sampled. It lasts one clock per matching bus cycle. `brk_trig` is high exactly when any channel requests.
- R10: A match sets the channel's sticky flag. Writing register index 5 with data bit 0 at 1 clears it. A match in the same cycle as the clear wins, and writing bit 0 at 0 leaves the flag unchanged.
- R11: The channels are independent. Each matches, flags and clears only on its own settings.
- R12: The register address is {channel, index[2:0]}. The indices are 0 address value, 1 address mask, 2 data value, 3 data mask, 4 control, 5 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | {channel, register index} |
| cfg_wdata | input | 32 | Register write data |
| fb_vld | input | 1 | Fetch bus cycle valid |
| fb_addr | input | 32 | Fetch bus address |
| mb_vld | input | 1 | Memory bus cycle valid |
| mb_addr | input | 32 | Memory bus address |
| mb_data | input | 32 | Memory bus data |
| mb_wr | input | 1 | Memory bus write (1) or read (0) |
| mb_size | input | 2 | Memory bus size code (1 byte, 2 word, 3 long) |
| ic_vld | input | 1 | Internal CPU bus cycle valid |
| ic_addr | input | 32 | Internal CPU bus address |
| ic_data | input | 32 | Internal CPU bus data |
| ic_wr | input | 1 | Internal CPU bus write |
| ic_size | input | 2 | Internal CPU bus size code |
| id_vld | input | 1 | Internal DMA bus cycle valid |
| id_addr | input | 32 | Internal DMA bus address |
| id_data | input | 32 | Internal DMA bus data |
| id_wr | input | 1 | Internal DMA bus write |
| id_size | input | 2 | Internal DMA bus size code |
| brk_req | output | 2 | Per-channel break request pulse |
| brk_after | output | 2 | Per-channel break-after-execution marker |
| brk_trig | output | 1 | Shared trigger pulse |
| brk_flag | output | 2 | Per-channel sticky match flag |

## Verification
A corrupted configuration register causes no activity by itself. It shows only on the next bus cycle that crosses the bad field, as a missing or extra request one clock later. For that reason the tests sweep each field against accesses on both sides of its boundary. A wrong sticky flag is visible on `brk_flag` at once and persists. A mis-routed bus select shows as a request tied to the wrong valid input on the following clock.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  localparam logic [IDX_W-1:0] REG_AVAL = 3'd0;
  localparam logic [IDX_W-1:0] REG_AMSK = 3'd1;
  localparam logic [IDX_W-1:0] REG_DVAL = 3'd2;
  localparam logic [IDX_W-1:0] REG_DMSK = 3'd3;
  localparam logic [IDX_W-1:0] REG_CTRL = 3'd4;
  localparam logic [IDX_W-1:0] REG_CLR  = 3'd5;

  typedef enum logic [1:0] {CYC_ANY = 2'd0, CYC_FETCH = 2'd1, CYC_DATA = 2'd2, CYC_NONE = 2'd3} cyc_e;
  typedef enum logic [1:0] {DIR_ANY = 2'd0, DIR_RD = 2'd1, DIR_WR = 2'd2, DIR_NONE = 2'd3} dir_e;
  typedef enum logic [1:0] {SZ_ANY = 2'd0, SZ_BYTE = 2'd1, SZ_WORD = 2'd2, SZ_LONG = 2'd3} size_e;

  // control word: bit0 en, bit1 internal side, bit2 dma master,
  // bits4:3 cycle, bits6:5 direction, bits8:7 size, bit9 after
  typedef struct packed {
    logic  after;
    size_e size;
    dir_e  dir;
    cyc_e  cyc;
    logic  ibus_dma;
    logic  side_int;
    logic  en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef struct packed {
    logic [ADDR_W-1:0] aval;
    logic [ADDR_W-1:0] amsk;
    logic [DATA_W-1:0] dval;
    logic [DATA_W-1:0] dmsk;
    ctrl_t             ctrl;
  } cfg_t;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              wr;
    size_e             size;
  } acc_t;
endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
  import brk_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHW + IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RAW-1:0]       waddr,
  input  logic [ADDR_W-1:0]    wdata,
  output cfg_t [NCH-1:0]       cfg_o,
  output logic [NCH-1:0]       clr_o
);
  logic [CHW-1:0]   sel_ch;
  logic [IDX_W-1:0] sel_idx;

  assign sel_ch  = waddr[IDX_W +: CHW];
  assign sel_idx = waddr[IDX_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit_ch;
    cfg_t r;
    assign hit_ch = we && (sel_ch == CHW'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (hit_ch) begin
        case (sel_idx)
          REG_AVAL: r.aval <= wdata;
          REG_AMSK: r.amsk <= wdata;
          REG_DVAL: r.dval <= DATA_W'(wdata);
          REG_DMSK: r.dmsk <= DATA_W'(wdata);
          REG_CTRL: r.ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
          default:  ;
        endcase
      end
    end

    assign cfg_o[c] = r;
    assign clr_o[c] = hit_ch && (sel_idx == REG_CLR) && wdata[0];
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
(
  input  cfg_t cfg,
  input  acc_t acc,
  input  logic is_fetch,
  output logic hit
);
  logic a_ok, d_ok, dir_ok, sz_ok;

  always_comb begin
    a_ok = (((acc.addr ^ cfg.aval) & ~cfg.amsk) == '0);
    d_ok = is_fetch || (((acc.data ^ cfg.dval) & ~cfg.dmsk) == '0);

    case (cfg.ctrl.dir)
      DIR_ANY: dir_ok = 1'b1;
      DIR_RD:  dir_ok = !acc.wr;
      DIR_WR:  dir_ok = acc.wr;
      default: dir_ok = 1'b0;
    endcase
    if (is_fetch) dir_ok = 1'b1;

    sz_ok = is_fetch || (cfg.ctrl.size == SZ_ANY) || (cfg.ctrl.size == acc.size);

    hit = acc.vld && a_ok && d_ok && dir_ok && sz_ok;
  end
endmodule

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg,
  input  acc_t fb,
  input  acc_t mb,
  input  acc_t ic,
  input  acc_t id,
  input  logic clr,
  output logic hit,
  output logic req,
  output logic after,
  output logic flag
);
  acc_t ib;
  logic f_raw, m_raw, i_raw;
  logic cyc_f_ok, cyc_d_ok;
  logic f_hit, m_hit, i_hit;

  assign ib = cfg.ctrl.ibus_dma ? id : ic;

  brk_match u_mf (.cfg(cfg), .acc(fb), .is_fetch(1'b1), .hit(f_raw));
  brk_match u_mm (.cfg(cfg), .acc(mb), .is_fetch(1'b0), .hit(m_raw));
  brk_match u_mi (.cfg(cfg), .acc(ib), .is_fetch(1'b0), .hit(i_raw));

  assign cyc_f_ok = (cfg.ctrl.cyc == CYC_ANY) || (cfg.ctrl.cyc == CYC_FETCH);
  assign cyc_d_ok = (cfg.ctrl.cyc == CYC_ANY) || (cfg.ctrl.cyc == CYC_DATA);

  assign f_hit = cfg.ctrl.en && !cfg.ctrl.side_int && cyc_f_ok && f_raw;
  assign m_hit = cfg.ctrl.en && !cfg.ctrl.side_int && cyc_d_ok && m_raw;
  assign i_hit = cfg.ctrl.en &&  cfg.ctrl.side_int && cyc_d_ok && i_raw;
  assign hit   = f_hit || m_hit || i_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req   <= 1'b0;
      after <= 1'b0;
      flag  <= 1'b0;
    end else begin
      req   <= hit;
      after <= f_hit && cfg.ctrl.after;
      flag  <= (flag && !clr) || hit;
    end
  end
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
  import brk_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHW + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [RAW-1:0]    cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              fb_vld,
  input  logic [31:0]       fb_addr,
  input  logic              mb_vld,
  input  logic [31:0]       mb_addr,
  input  logic [31:0]       mb_data,
  input  logic              mb_wr,
  input  logic [1:0]        mb_size,
  input  logic              ic_vld,
  input  logic [31:0]       ic_addr,
  input  logic [31:0]       ic_data,
  input  logic              ic_wr,
  input  logic [1:0]        ic_size,
  input  logic              id_vld,
  input  logic [31:0]       id_addr,
  input  logic [31:0]       id_data,
  input  logic              id_wr,
  input  logic [1:0]        id_size,
  output logic [NCH-1:0]    brk_req,
  output logic [NCH-1:0]    brk_after,
  output logic              brk_trig,
  output logic [NCH-1:0]    brk_flag
);
  cfg_t [NCH-1:0] cfg;
  logic [NCH-1:0] clr;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] ch_en;
  acc_t fb, mb, ic, id;

  assign fb = '{vld: fb_vld, addr: fb_addr, data: '0, wr: 1'b0, size: SZ_ANY};
  assign mb = '{vld: mb_vld, addr: mb_addr, data: mb_data, wr: mb_wr, size: size_e'(mb_size)};
  assign ic = '{vld: ic_vld, addr: ic_addr, data: ic_data, wr: ic_wr, size: size_e'(ic_size)};
  assign id = '{vld: id_vld, addr: id_addr, data: id_data, wr: id_wr, size: size_e'(id_size)};

  brk_cfg_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
    .wdata(cfg_wdata), .cfg_o(cfg), .clr_o(clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign ch_en[c] = cfg[c].ctrl.en;
    brk_chan u_chan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[c]),
      .fb(fb), .mb(mb), .ic(ic), .id(id), .clr(clr[c]),
      .hit(hit[c]), .req(brk_req[c]), .after(brk_after[c]), .flag(brk_flag[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) brk_trig <= 1'b0;
    else        brk_trig <= |hit;
  end
endmodule

// File: rtl/brk_chk.sv
module brk_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] after,
  input logic           trig,
  input logic [NCH-1:0] flag,
  input logic           any_vld,
  input logic [NCH-1:0] en
);
  a_r9_trig_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    trig == (|req));

  a_r8_after_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    (after & ~req) == '0);

  a_r10_flag_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~flag) == '0);

  a_r9_req_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> $past(any_vld));

  a_r7_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req & ~$past(en)) == '0);
endmodule

bind dbg_break_unit brk_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(brk_req), .after(brk_after), .trig(brk_trig),
  .flag(brk_flag), .any_vld(fb_vld | mb_vld | ic_vld | id_vld), .en(ch_en)
);

// File: tb/dbg_break_unit_test.sv
module dbg_break_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic fb_vld = 0, mb_vld = 0, ic_vld = 0, id_vld = 0;
  logic [31:0] fb_addr = '0, mb_addr = '0, ic_addr = '0, id_addr = '0;
  logic [31:0] mb_data = '0, ic_data = '0, id_data = '0;
  logic mb_wr = 0, ic_wr = 0, id_wr = 0;
  logic [1:0] mb_size = 0, ic_size = 0, id_size = 0;
  logic [1:0] brk_req, brk_after, brk_flag;
  logic brk_trig;

  int checks = 0;
  int errors = 0;
  logic [1:0] s_req, s_after, s_flag;
  logic s_trig;

  always #4 clk = ~clk;

  dbg_break_unit uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R12: address = {channel, index}
  task automatic wreg(int ch, int idx, logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_addr = {ch[0], idx[2:0]}; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] ctl(bit en, bit side, bit dma, int cyc, int dir, int sz, bit aft);
    return {22'd0, aft, sz[1:0], dir[1:0], cyc[1:0], dma, side, en};
  endfunction

  task automatic setch(int ch, logic [31:0] a, logic [31:0] am, logic [31:0] d, logic [31:0] dm, logic [31:0] c);
    wreg(ch, 0, a); wreg(ch, 1, am); wreg(ch, 2, d); wreg(ch, 3, dm); wreg(ch, 4, c);
  endtask

  // bus 0 fetch, 1 memory, 2 internal cpu, 3 internal dma
  task automatic fire(int bus, logic [31:0] a, logic [31:0] d, bit wr, int sz);
    @(negedge clk);
    case (bus)
      0: begin fb_vld = 1; fb_addr = a; end
      1: begin mb_vld = 1; mb_addr = a; mb_data = d; mb_wr = wr; mb_size = sz[1:0]; end
      2: begin ic_vld = 1; ic_addr = a; ic_data = d; ic_wr = wr; ic_size = sz[1:0]; end
      default: begin id_vld = 1; id_addr = a; id_data = d; id_wr = wr; id_size = sz[1:0]; end
    endcase
    @(negedge clk);
    s_req = brk_req; s_after = brk_after; s_trig = brk_trig; s_flag = brk_flag;
    fb_vld = 0; mb_vld = 0; ic_vld = 0; id_vld = 0;
  endtask

  task automatic t_reset;
    chk("R7 reset req", {30'd0, brk_req}, 0);
    chk("R7 reset flag", {30'd0, brk_flag}, 0);
    chk("R9 reset trig", {31'd0, brk_trig}, 0);
    fire(0, 32'h0, 0, 0, 0);
    chk("R7 disabled fetch", {30'd0, s_req}, 0);
    fire(1, 32'h0, 0, 0, 3);
    chk("R7 disabled mem", {30'd0, s_req}, 0);
  endtask

  task automatic t_addr_mask;
    setch(0, 32'h1000_0040, 32'h0000_000F, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 2, 0, 0, 0));
    fire(1, 32'h1000_004C, 0, 0, 3);
    chk("R1 masked bits hit", {30'd0, s_req}, 1);
    fire(1, 32'h1000_0050, 0, 0, 3);
    chk("R1 unmasked bit miss", {30'd0, s_req}, 0);
    wreg(0, 1, 32'hFFFF_FFFF);
    fire(1, 32'hDEAD_BEEF, 0, 0, 3);
    chk("R1 full mask hit", {30'd0, s_req}, 1);
    wreg(0, 5, 1);
  endtask

  task automatic t_data_mask;
    setch(0, 0, 32'hFFFF_FFFF, 32'hAB00_00CD, 32'h00FF_FF00, ctl(1, 0, 0, 2, 0, 0, 0));
    fire(1, 32'h5, 32'hAB12_34CD, 1, 3);
    chk("R2 data masked hit", {30'd0, s_req}, 1);
    fire(1, 32'h5, 32'hAC00_00CD, 1, 3);
    chk("R2 data miss", {30'd0, s_req}, 0);
    wreg(0, 5, 1);
  endtask

  task automatic t_cpu_side;
    setch(0, 32'h0000_2000, 0, 32'h1, 0, ctl(1, 0, 0, 1, 0, 0, 0));
    fire(0, 32'h2000, 0, 0, 0);
    chk("R3 fetch sel fetch bus", {30'd0, s_req}, 1);
    chk("R8 before exec", {30'd0, s_after}, 0);
    fire(1, 32'h2000, 32'h1, 0, 3);
    chk("R3 fetch sel mem bus", {30'd0, s_req}, 0);
    wreg(0, 4, ctl(1, 0, 0, 2, 0, 0, 0));
    fire(0, 32'h2000, 0, 0, 0);
    chk("R3 data sel fetch bus", {30'd0, s_req}, 0);
    fire(1, 32'h2000, 32'h1, 0, 3);
    chk("R3 data sel mem bus", {30'd0, s_req}, 1);
    wreg(0, 4, ctl(1, 0, 0, 0, 0, 0, 0));
    fire(0, 32'h2000, 0, 0, 0);
    chk("R3 any fetch", {30'd0, s_req}, 1);
    fire(1, 32'h2000, 32'h1, 0, 3);
    chk("R3 any mem", {30'd0, s_req}, 1);
    fire(2, 32'h2000, 32'h1, 0, 3);
    chk("R3 cpu side ignores internal", {30'd0, s_req}, 0);
    wreg(0, 5, 1);
  endtask

  task automatic t_internal;
    setch(0, 32'h3000, 0, 32'h7, 0, ctl(1, 1, 0, 2, 0, 0, 0));
    fire(2, 32'h3000, 32'h7, 0, 2);
    chk("R4 internal cpu hit", {30'd0, s_req}, 1);
    fire(3, 32'h3000, 32'h7, 0, 2);
    chk("R4 dma ignored", {30'd0, s_req}, 0);
    fire(1, 32'h3000, 32'h7, 0, 2);
    chk("R4 mem ignored", {30'd0, s_req}, 0);
    wreg(0, 4, ctl(1, 1, 1, 2, 0, 0, 0));
    fire(3, 32'h3000, 32'h7, 0, 2);
    chk("R4 dma hit", {30'd0, s_req}, 1);
    fire(2, 32'h3000, 32'h7, 0, 2);
    chk("R4 cpu ignored", {30'd0, s_req}, 0);
    wreg(0, 4, ctl(1, 1, 0, 1, 0, 0, 0));
    fire(2, 32'h3000, 32'h7, 0, 2);
    chk("R4 fetch on internal never", {30'd0, s_req}, 0);
    wreg(0, 5, 1);
  endtask

  task automatic t_dir;
    setch(0, 32'h40, 0, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 2, 1, 0, 0));
    fire(1, 32'h40, 0, 1, 1);
    chk("R5 read-only write miss", {30'd0, s_req}, 0);
    fire(1, 32'h40, 0, 0, 1);
    chk("R5 read-only read hit", {30'd0, s_req}, 1);
    wreg(0, 4, ctl(1, 0, 0, 2, 2, 0, 0));
    fire(1, 32'h40, 0, 0, 1);
    chk("R5 write-only read miss", {30'd0, s_req}, 0);
    fire(1, 32'h40, 0, 1, 1);
    chk("R5 write-only write hit", {30'd0, s_req}, 1);
    wreg(0, 4, ctl(1, 0, 0, 2, 3, 0, 0));
    fire(1, 32'h40, 0, 1, 1);
    chk("R5 none write", {30'd0, s_req}, 0);
    fire(1, 32'h40, 0, 0, 1);
    chk("R5 none read", {30'd0, s_req}, 0);
    wreg(0, 5, 1);
  endtask

  task automatic t_size;
    setch(0, 32'h80, 0, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 2, 0, 3, 0));
    fire(1, 32'h80, 0, 0, 1);
    chk("R6 long-only byte miss", {30'd0, s_req}, 0);
    fire(1, 32'h80, 0, 0, 3);
    chk("R6 long-only long hit", {30'd0, s_req}, 1);
    wreg(0, 4, ctl(1, 0, 0, 2, 0, 2, 0));
    fire(1, 32'h80, 0, 0, 2);
    chk("R6 word hit", {30'd0, s_req}, 1);
    wreg(0, 4, ctl(1, 0, 0, 1, 2, 1, 0));
    fire(0, 32'h80, 0, 0, 0);
    chk("R6 fetch ignores size dir", {30'd0, s_req}, 1);
    wreg(0, 5, 1);
  endtask

  task automatic t_after;
    setch(0, 32'h100, 0, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 0, 0, 0, 1));
    fire(0, 32'h100, 0, 0, 0);
    chk("R8 after on fetch req", {30'd0, s_req}, 1);
    chk("R8 after on fetch", {30'd0, s_after}, 1);
    fire(1, 32'h100, 0, 0, 3);
    chk("R8 data hit no after", {30'd0, s_after}, 0);
    chk("R8 data hit req", {30'd0, s_req}, 1);
    wreg(0, 5, 1);
  endtask

  task automatic t_pulse;
    setch(0, 32'h200, 0, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 2, 0, 0, 0));
    @(negedge clk);
    mb_vld = 1; mb_addr = 32'h200; mb_size = 3; mb_wr = 0;
    #1;
    chk("R9 no same-cycle req", {30'd0, brk_req}, 0);
    @(negedge clk);
    chk("R9 req after one clock", {30'd0, brk_req}, 1);
    chk("R9 trig with req", {31'd0, brk_trig}, 1);
    @(negedge clk);
    chk("R9 second bus cycle req", {30'd0, brk_req}, 1);
    mb_vld = 0;
    @(negedge clk);
    chk("R9 req drops", {30'd0, brk_req}, 0);
    chk("R9 trig drops", {31'd0, brk_trig}, 0);
  endtask

  task automatic t_flag;
    chk("R10 flag sticky", {30'd0, brk_flag}, 1);
    wreg(0, 5, 0);
    chk("R10 clear bit0=0 keeps", {30'd0, brk_flag}, 1);
    wreg(0, 5, 1);
    chk("R10 cleared", {30'd0, brk_flag}, 0);
    fire(1, 32'h200, 0, 0, 3);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'h5; cfg_wdata = 1;
    mb_vld = 1; mb_addr = 32'h200;
    @(negedge clk);
    cfg_we = 0; mb_vld = 0;
    chk("R10 set beats clear", {30'd0, brk_flag}, 1);
    wreg(0, 5, 1);
  endtask

  task automatic t_indep;
    setch(0, 32'hA00, 0, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 2, 0, 0, 0));
    setch(1, 32'hB00, 0, 0, 32'hFFFF_FFFF, ctl(1, 0, 0, 2, 0, 0, 0));
    fire(1, 32'hA00, 0, 0, 3);
    chk("R11 ch0 only", {30'd0, s_req}, 1);
    fire(1, 32'hB00, 0, 0, 3);
    chk("R11 ch1 only", {30'd0, s_req}, 2);
    chk("R11 both flags", {30'd0, s_flag}, 3);
    wreg(0, 5, 1);
    chk("R11 clear ch0 keeps ch1", {30'd0, brk_flag}, 2);
    wreg(1, 0, 32'hA00);
    fire(1, 32'hA00, 0, 0, 3);
    chk("R11 both hit", {30'd0, s_req}, 3);
    chk("R9 trig on both", {31'd0, s_trig}, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_addr_mask;
    t_data_mask;
    t_cpu_side;
    t_internal;
    t_dir;
    t_size;
    t_after;
    t_pulse;
    t_flag;
    t_indep;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule